// File: doc/BRIEF.md
# Six-Bit GPIO Port with Weak Pull-Up and Wake-on-Change

This block is the general-purpose I/O port of a small microcontroller. It holds a six-bit output latch and a six-bit direction register. It drives the per-pin output value, output enable and pull-up enable toward the pads. A port read returns the live pad levels rather than the latch contents. The bus side gives three commands: a port write, a direction write that carries the accumulator value, and a port read. The direction register cannot be read back. Bit 3 is input-only. Bit 2 can lose its driver to an option-register control. Pins taken by alternate functions read as zero.

A weak pull-up and wake-on-change serve a fixed group of pins: bits 0, 1 and 3. Each feature has one global enable. When bit 3 is set up as the external reset input, its pull-up is forced on and it is left out of wake detection. Wake detection compares the eligible pads against a snapshot taken at the last port read. A small state machine tracks this with three states:
- `WK_OFF`: wake disabled.
- `WK_WATCH`: armed, no mismatch seen yet.
- `WK_FLAG`: wake requested.

The transitions are:
- OFF→WATCH: enable set, no mismatch.
- OFF→FLAG: enable set and a mismatch present, with no read.
- WATCH→FLAG: mismatch present, with no read.
- FLAG→WATCH: port read.
- WATCH→OFF and FLAG→OFF: enable cleared.

Enable cleared takes priority over everything else. A read takes priority over a mismatch. The wake request is the FLAG state itself, so it stays high until a read or until the enable is cleared.

Top module: `gpio_wake_port`

## Requirements
- R1: Bits 7 and 6 of `rd_data` always read 0.
- R2: `rd_data[5:0]` shows the current `pad_in` level of every pin not marked in `alt_fn_mask`, whatever the latch or direction holds, in the same cycle.
- R3: A pin whose `alt_fn_mask` bit is 1 reads as 0 in `rd_data`.
- R4: After reset every direction bit is 1, so all `pad_oe` bits are 0 and `wake_req` is 0.
- R5: A direction write loads `wr_data` at the clock edge. From the next cycle a direction bit of 1 gives `pad_oe`=0, and a 0 gives `pad_oe`=1 with `pad_out` equal to the latch bit.
- R6: `pad_oe[3]` is never 1.
- R7: While `opt_pin2_override` is 1, `pad_oe[2]` is 0.
- R8: `pad_pu` bits 0, 1 and 3 equal `pu_enable`. Bits 2, 4 and 5 are always 0.
- R9: While `pin3_is_reset` is 1, `pad_pu[3]` is 1 regardless of `pu_enable`.
- R10: A port read stores pads 0, 1 and 3 as the snapshot. With `wake_enable` at 1, a cycle with no read in which an eligible pad differs from the snapshot raises `wake_req` from the next cycle.
- R11: `wake_req` stays 1 until a port read or a cycle with `wake_enable` at 0, and is 0 in the cycle after either.
- R12: Pins 2, 4 and 5 never cause a wake. Pin 3 causes none while `pin3_is_reset` is 1.
- R13: The output latch keeps its value until the next port write, including across direction changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_port_en | input | 1 | Port write strobe (loads output latch) |
| wr_dir_en | input | 1 | Direction write strobe (accumulator value) |
| wr_data | input | 6 | Write data for latch or direction |
| rd_port_en | input | 1 | Port read strobe (also takes wake snapshot) |
| rd_data | output | 8 | Port read value |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables, 1 = drive |
| pad_pu | output | 6 | Weak pull-up enables |
| alt_fn_mask | input | 6 | 1 = pin owned by an alternate function |
| pin3_is_reset | input | 1 | Bit 3 serves as external reset input |
| opt_pin2_override | input | 1 | Option control removing bit 2's driver |
| pu_enable | input | 1 | Global weak pull-up enable |
| wake_enable | input | 1 | Global wake-on-change enable |
| wake_req | output | 1 | Wake request |

## Verification
The following outputs are combinational and are due in the same cycle as their inputs: `rd_data`, `pad_pu`, and the override and input-only gating of `pad_oe`. Direction and latch writes show on `pad_oe` and `pad_out` one edge after the strobe. A wake request appears one edge after the mismatching cycle and clears one edge after a read or a disable. The bench drives stimulus on the falling edge and compares all outputs 1 ns later against a model that advances only at the rising edge, so each result is sampled exactly in the cycle it is due.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
    localparam int PORT_W  = 6;
    localparam int BUS_W   = 8;
    localparam int IN_ONLY_BIT = 3;
    localparam int OVR_BIT     = 2;
    localparam int RST_BIT     = 3;
    localparam logic [PORT_W-1:0] WAKE_GROUP = 6'b001011;
    localparam logic [PORT_W-1:0] IN_ONLY_MASK = PORT_W'(1) << IN_ONLY_BIT;
    localparam logic [PORT_W-1:0] OVR_MASK     = PORT_W'(1) << OVR_BIT;
    localparam logic [PORT_W-1:0] RST_MASK     = PORT_W'(1) << RST_BIT;

    typedef enum logic [1:0] {
        WK_OFF   = 2'd0,
        WK_WATCH = 2'd1,
        WK_FLAG  = 2'd2
    } wk_state_e;
endpackage

// File: rtl/gpio_dir_latch.sv
module gpio_dir_latch
    import gpio_wake_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_port_en,
    input  logic         wr_dir_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] lat_q
);
    localparam logic [W-1:0] DIR_RST = {W{1'b1}};

    // direction register: reset to all-input
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dir_q <= DIR_RST;
        else if (wr_dir_en)
            dir_q <= wr_data;
    end

    // output latch: no reset, holds until rewritten
    always_ff @(posedge clk) begin
        if (wr_port_en)
            lat_q <= wr_data;
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir_en |=> dir_q == $past(wr_data)); // R5
    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_port_en |=> $stable(lat_q)); // R13
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_wake_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lat_q,
    input  logic         opt_pin2_override,
    input  logic         pu_enable,
    input  logic         pin3_is_reset,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    logic [W-1:0] no_drive;

    always_comb begin
        no_drive = IN_ONLY_MASK | (opt_pin2_override ? OVR_MASK : '0);
        pad_oe   = ~dir_q & ~no_drive;
        pad_out  = lat_q & ~IN_ONLY_MASK;
        pad_pu   = (pu_enable ? WAKE_GROUP : '0) | (pin3_is_reset ? RST_MASK : '0);
    end
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
    import gpio_wake_pkg::*;
#(
    parameter int W = PORT_W,
    parameter int B = BUS_W
) (
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] alt_fn_mask,
    output logic [B-1:0] rd_data
);
    localparam int PAD_BITS = B - W;

    always_comb begin
        rd_data = {{PAD_BITS{1'b0}}, pad_in & ~alt_fn_mask};
    end
endmodule

// File: rtl/gpio_wake_fsm.sv
module gpio_wake_fsm
    import gpio_wake_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wake_enable,
    input  logic         rd_port_en,
    input  logic         pin3_is_reset,
    input  logic [W-1:0] pad_in,
    output logic         wake_req
);
    wk_state_e    state_q, state_d;
    logic [W-1:0] snap_q;
    logic [W-1:0] eligible;
    logic         mismatch;
    logic         fire;

    always_comb begin
        eligible = pin3_is_reset ? (WAKE_GROUP & ~RST_MASK) : WAKE_GROUP;
        mismatch = |((pad_in ^ snap_q) & eligible);
        fire     = mismatch && !rd_port_en;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_OFF:   if (wake_enable) state_d = fire ? WK_FLAG : WK_WATCH;
            WK_WATCH: if (!wake_enable) state_d = WK_OFF;
                      else if (fire)     state_d = WK_FLAG;
            WK_FLAG:  if (!wake_enable) state_d = WK_OFF;
                      else if (rd_port_en) state_d = WK_WATCH;
            default:  state_d = WK_OFF;
        endcase
    end

    // state register and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WK_OFF;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_port_en)
                snap_q <= pad_in & WAKE_GROUP;
        end
    end

    // outputs
    always_comb begin
        wake_req = (state_q == WK_FLAG);
    end

    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_enable |=> !wake_req); // R11
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_port_en |=> !wake_req); // R11
    AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(wake_enable) && !$past(rd_port_en)); // R10
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
    import gpio_wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_port_en,
    input  logic              wr_dir_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rd_port_en,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu,
    input  logic [PORT_W-1:0] alt_fn_mask,
    input  logic              pin3_is_reset,
    input  logic              opt_pin2_override,
    input  logic              pu_enable,
    input  logic              wake_enable,
    output logic              wake_req
);
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] lat_q;

    gpio_dir_latch #(.W(PORT_W)) i_dir_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_port_en (wr_port_en),
        .wr_dir_en  (wr_dir_en),
        .wr_data    (wr_data),
        .dir_q      (dir_q),
        .lat_q      (lat_q)
    );

    gpio_pad_ctrl #(.W(PORT_W)) i_pad_ctrl (
        .dir_q             (dir_q),
        .lat_q             (lat_q),
        .opt_pin2_override (opt_pin2_override),
        .pu_enable         (pu_enable),
        .pin3_is_reset     (pin3_is_reset),
        .pad_out           (pad_out),
        .pad_oe            (pad_oe),
        .pad_pu            (pad_pu)
    );

    gpio_read_path #(.W(PORT_W), .B(BUS_W)) i_read_path (
        .pad_in      (pad_in),
        .alt_fn_mask (alt_fn_mask),
        .rd_data     (rd_data)
    );

    gpio_wake_fsm #(.W(PORT_W)) i_wake_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wake_enable   (wake_enable),
        .rd_port_en    (rd_port_en),
        .pin3_is_reset (pin3_is_reset),
        .pad_in        (pad_in),
        .wake_req      (wake_req)
    );

    AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & dir_q) == '0); // R5
    AST_IN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[IN_ONLY_BIT]); // R6
    AST_PIN2_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        opt_pin2_override |-> !pad_oe[OVR_BIT]); // R7
    AST_RST_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        pin3_is_reset |-> pad_pu[RST_BIT]); // R9
endmodule

// File: tb/test_gpio_wake_port.sv
`timescale 1ns/1ps
module test_gpio_wake_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_port_en = 0, wr_dir_en = 0, rd_port_en = 0;
    logic [5:0] wr_data = 0, pad_in = 0, alt_fn_mask = 0;
    logic       pin3_is_reset = 0, opt_pin2_override = 0, pu_enable = 0, wake_enable = 0;
    logic [7:0] rd_data;
    logic [5:0] pad_out, pad_oe, pad_pu;
    logic       wake_req;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [5:0] m_dir, m_lat, m_snap;
    logic       m_latv, m_wake;

    always #4 clk = ~clk;

    gpio_wake_port i_gpio_wake_port (
        .clk(clk), .rst_n(rst_n), .wr_port_en(wr_port_en), .wr_dir_en(wr_dir_en),
        .wr_data(wr_data), .rd_port_en(rd_port_en), .rd_data(rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .alt_fn_mask(alt_fn_mask),
        .pin3_is_reset(pin3_is_reset), .opt_pin2_override(opt_pin2_override),
        .pu_enable(pu_enable), .wake_enable(wake_enable), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] exp_oe(input logic [5:0] d, input logic ovr);
        exp_oe = ~d & ~6'b001000 & (ovr ? ~6'b000100 : 6'b111111);
    endfunction

    function automatic logic [5:0] exp_pu(input logic pu, input logic r3);
        exp_pu = (pu ? 6'b001011 : 6'b0) | (r3 ? 6'b001000 : 6'b0);
    endfunction

    function automatic logic exp_mism(input logic [5:0] pin, input logic [5:0] snap, input logic r3);
        logic [5:0] e;
        e = r3 ? 6'b000011 : 6'b001011;
        exp_mism = |((pin ^ snap) & e);
    endfunction

    // check outputs now, then advance model at the rising edge
    task automatic tick();
        logic [5:0] oe;
        #1;
        oe = exp_oe(m_dir, opt_pin2_override);
        chk("R1 rd_data[7:6]", {6'b0, rd_data[7:6]}, 8'h00);
        chk("R2 R3 rd_data", {2'b0, rd_data[5:0]}, {2'b0, pad_in & ~alt_fn_mask});
        chk("R5 R6 R7 pad_oe", {2'b0, pad_oe}, {2'b0, oe});
        chk("R6 pad_oe[3]", {7'b0, pad_oe[3]}, 8'h00);
        if (opt_pin2_override) chk("R7 pad_oe[2]", {7'b0, pad_oe[2]}, 8'h00);
        if (m_latv) chk("R5 R13 pad_out", {2'b0, pad_out & oe}, {2'b0, m_lat & oe});
        chk("R8 R9 pad_pu", {2'b0, pad_pu}, {2'b0, exp_pu(pu_enable, pin3_is_reset)});
        chk("R10 R11 R12 wake_req", {7'b0, wake_req}, {7'b0, m_wake});
        @(posedge clk);
        if (!wake_enable) m_wake = 1'b0;
        else if (rd_port_en) m_wake = 1'b0;
        else if (exp_mism(pad_in, m_snap, pin3_is_reset)) m_wake = 1'b1;
        if (rd_port_en) m_snap = pad_in & 6'b001011;
        if (wr_port_en) begin m_lat = wr_data; m_latv = 1'b1; end
        if (wr_dir_en) m_dir = wr_data;
        @(negedge clk);
        wr_port_en = 0; wr_dir_en = 0; rd_port_en = 0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_dir = 6'h3F; m_lat = 0; m_snap = 0; m_latv = 0; m_wake = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R4 pad_oe after reset", {2'b0, pad_oe}, 8'h00);
        chk("R4 wake_req after reset", {7'b0, wake_req}, 8'h00);
        tick();

        // R13 / R2: latch held across direction changes; read sees pads not latch
        wr_data = 6'b110111; wr_port_en = 1; tick();
        wr_data = 6'b000000; wr_dir_en = 1; tick();
        chk("R13 latch after dir write", {2'b0, pad_out & 6'b110111}, {2'b0, 6'b110111});
        wr_data = 6'b111111; wr_dir_en = 1; tick();
        wr_data = 6'b000000; wr_dir_en = 1; pad_in = 6'b000000; #1;
        chk("R2 pad low though latch high", rd_data, 8'h00);
        tick();
        chk("R13 latch kept", {2'b0, pad_out & 6'b110111}, {2'b0, 6'b110111});

        // R12: pin3 as reset and pins 2,4,5 do not wake
        pin3_is_reset = 1; wake_enable = 1; pad_in = 0; rd_port_en = 1; tick();
        pad_in = 6'b111100; tick(); tick();
        chk("R12 no wake from 2,3,4,5", {7'b0, wake_req}, 8'h00);
        pad_in = 6'b111101; tick();
        chk("R10 wake from pin0", {7'b0, wake_req}, 8'h01);
        pad_in = 6'b111100; tick();
        chk("R11 wake held", {7'b0, wake_req}, 8'h01);
        rd_port_en = 1; tick();
        chk("R11 read clears", {7'b0, wake_req}, 8'h00);
        pin3_is_reset = 0; pu_enable = 0; #1;
        chk("R9 pu3 off without reset cfg", {2'b0, pad_pu}, 8'h00);
        pin3_is_reset = 1; #1;
        chk("R9 pu3 forced", {2'b0, pad_pu}, 8'h08);
        tick();

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            wr_port_en = ($urandom % 4) == 0;
            wr_dir_en  = ($urandom % 5) == 0;
            rd_port_en = ($urandom % 5) == 0;
            wr_data    = 6'($urandom);
            if (($urandom % 3) == 0) pad_in = 6'($urandom);
            alt_fn_mask = 6'($urandom) & 6'($urandom);
            if (($urandom % 16) == 0) pin3_is_reset = ~pin3_is_reset;
            opt_pin2_override = ($urandom % 3) == 0;
            pu_enable   = ($urandom % 2) == 0;
            wake_enable = ($urandom % 8) != 0;
            tick();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule